// File: doc/BRIEF.md
# OUT Endpoint Bank Manager

This block manages the receive buffers of one USB OUT endpoint. The buffers are one or two banks of 64 bytes. The packet layer streams each OUT payload a byte at a time, then marks the end of the packet. If a bank is free, the payload is stored and answered with ACK. If no bank is free, the payload is dropped and answered with NAK. Banks are filled in strict round-robin order.

On the firmware side, a filled bank is handed over by raising two flags: a received flag, which can drive an interrupt, and a bank-busy flag. Firmware then pulls bytes through a read port and watches a remaining-byte counter. The received flag and the bank-busy flag are cleared by separate strobes. Clearing the received flag only acknowledges the interrupt. Clearing the bank-busy flag gives the bank back to the packet layer and moves the firmware side to the next bank. If that bank already holds a packet, both flags rise again one cycle later.

The configuration inputs (enable, dual-bank mode) are expected to be static while the endpoint is enabled. The packet layer never raises its end strobe in the same cycle as a byte strobe.

Top module: `outep_bank_mgr`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with `cfg_enable` low, `rx_flag`, `bank_busy`, `irq` and `cpu_byte_cnt` are all 0. While disabled, a packet end is answered with `hs_valid`=1 and `hs_ack`=0, and nothing is stored.
- R2: A packet accepted into a free bank gives `hs_valid`=1 and `hs_ack`=1 in the cycle after the end strobe. In the cycle after that, `rx_flag` and `bank_busy` are 1 and `cpu_byte_cnt` equals the number of bytes received.
- R3: `irq` is 1 exactly when `rx_flag` is 1 and `irq_en` is 1.
- R4: A `cpu_clr_rx` strobe clears `rx_flag` (and so `irq`) on the next cycle. It leaves `bank_busy`, `cpu_byte_cnt` and the bank contents unchanged.
- R5: `cpu_rd_data` shows the bank's bytes in arrival order. Each `cpu_rd` strobe while `bank_busy` is 1 and `cpu_byte_cnt` is nonzero moves to the next byte and decrements `cpu_byte_cnt` by one. A strobe at count 0 changes nothing.
- R6: A `cpu_clr_busy` strobe while `bank_busy` is 1 frees the bank. On the next cycle `bank_busy` and `cpu_byte_cnt` are 0. In dual-bank mode (`cfg_dual`=1) the firmware side moves on to the other bank.
- R7: In dual-bank mode, packets go to bank 0 and bank 1 alternately. A second packet is accepted while the first one is still held by firmware.
- R8: A packet that arrives while the next bank in round-robin order is still held is answered with `hs_ack`=0. Its bytes are discarded and the held data is unchanged.
- R9: If the bank the firmware side moves to already holds a packet, `bank_busy` is 0 for exactly one cycle after the release. Then `rx_flag` and `bank_busy` are 1 and `cpu_byte_cnt` shows that packet's length.
- R10: A zero-length packet is accepted and stored. It raises both flags with `cpu_byte_cnt`=0.
- R11: Bytes beyond the 64th byte of a packet are dropped. `cpu_byte_cnt` saturates at 64, and the first 64 bytes are kept.
- R12: In single-bank mode, a packet sent while the bank is held is answered with NAK. After the release, the next packet is accepted.
- R13: A `cpu_clr_busy` strobe while `bank_busy` is 0 has no effect: the firmware side does not change bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Endpoint enabled; low clears all bank state |
| cfg_dual | input | 1 | 1: two banks in rotation, 0: bank 0 only |
| irq_en | input | 1 | Interrupt enable for the received flag |
| pkt_wr | input | 1 | Packet-layer byte strobe |
| pkt_data | input | 8 | Payload byte written with `pkt_wr` |
| pkt_end | input | 1 | End-of-packet strobe (also marks a zero-length packet) |
| hs_valid | output | 1 | Handshake result valid, one cycle after `pkt_end` |
| hs_ack | output | 1 | 1: ACK (stored), 0: NAK (dropped) |
| cpu_rd | input | 1 | Firmware read strobe, advances to the next byte |
| cpu_rd_data | output | 8 | Byte at the current read position |
| cpu_byte_cnt | output | 7 | Bytes still unread in the current bank |
| cpu_clr_rx | input | 1 | Strobe clearing the received flag |
| cpu_clr_busy | input | 1 | Strobe releasing the current bank |
| rx_flag | output | 1 | Received flag |
| bank_busy | output | 1 | Current bank held by firmware |
| irq | output | 1 | Interrupt request |

## Verification
Every cycle, the assertions check that a held bank is always marked full. They also check that the NAK path fires whenever the next bank is occupied. Other cycle-by-cycle checks: the read counter steps down by one per read and holds at zero, clearing the received flag never drops the bank, a release in dual mode always moves the firmware pointer, an idle release never moves it, and the flags are cleared after a disabled cycle. Some behaviour needs whole packet sequences and only the bench scenarios can show it. This covers the byte order seen on the read port, saturation at 64 bytes, zero-length packets, the round-robin placement across banks, and the one-cycle gap before an already-filled next bank is presented.

// File: rtl/outep_pkg.sv
// Package: shared sizing constants for the OUT endpoint bank manager.
// Assumes byte-wide payloads and at most two banks per endpoint.
package outep_pkg;
    localparam int unsigned EP_DATA_W     = 8;
    localparam int unsigned EP_BANK_BYTES = 64;
    localparam int unsigned EP_NBANKS     = 2;
endpackage

// File: rtl/outep_bank_store.sv
// Module: outep_bank_store
// Holds the payload bytes of every bank. There is one synchronous write
// port (used by the packet side) and one asynchronous read port (used by
// the firmware side). Assumes the two sides never address the same bank
// in the same cycle for a write and a meaningful read.
module outep_bank_store #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned BANK_BYTES = 64,
    parameter int unsigned NBANKS     = 2,
    localparam int unsigned ADDR_W    = $clog2(BANK_BYTES),
    localparam int unsigned PTR_W     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [NBANKS-1:0][DATA_W-1:0] rd_lane;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [DATA_W-1:0] cells [BANK_BYTES];

        // Store a payload byte when the write targets this bank.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == PTR_W'(b))) begin
                cells[wr_addr] <= wr_data;
            end
        end

        assign rd_lane[b] = cells[rd_addr];
    end

    assign rd_data = rd_lane[rd_bank];

endmodule

// File: rtl/outep_host_side.sv
// Module: outep_host_side
// Packet-facing half. It decides at the first event of a packet whether
// the packet is taken, counts and places its bytes, commits the bank at
// the end strobe, and returns ACK or NAK. It owns the per-bank "full" bits
// and the stored lengths. Assumes pkt_end never coincides with pkt_wr.
module outep_host_side #(
    parameter int unsigned BANK_BYTES = 64,
    parameter int unsigned NBANKS     = 2,
    localparam int unsigned ADDR_W    = $clog2(BANK_BYTES),
    localparam int unsigned CNT_W     = $clog2(BANK_BYTES + 1),
    localparam int unsigned PTR_W     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_enable,
    input  logic                         cfg_dual,
    input  logic                         pkt_wr,
    input  logic                         pkt_end,
    input  logic                         rel_pulse,
    input  logic [PTR_W-1:0]             rel_bank,
    output logic                         wr_en,
    output logic [PTR_W-1:0]             wr_bank,
    output logic [ADDR_W-1:0]            wr_addr,
    output logic [NBANKS-1:0]            full_vec,
    output logic [NBANKS-1:0][CNT_W-1:0] bank_len,
    output logic                         hs_valid,
    output logic                         hs_ack
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BANK_BYTES);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBANKS - 1);

    logic              rcv_act;
    logic              rcv_ok;
    logic [CNT_W-1:0]  wr_cnt;
    logic [PTR_W-1:0]  hptr;
    logic [PTR_W-1:0]  hptr_next;
    logic [NBANKS-1:0] full_q;
    logic              rcv_start;
    logic              accept_now;
    logic              take;
    logic              commit;

    // Decide acceptance and derive the write and commit strobes.
    always_comb begin
        rcv_start  = !rcv_act && (pkt_wr || pkt_end);
        accept_now = cfg_enable && !full_q[hptr];
        take       = rcv_act ? rcv_ok : accept_now;
        wr_en      = cfg_enable && pkt_wr && take && (wr_cnt < CNT_FULL);
        commit     = cfg_enable && pkt_end && take;
        hptr_next  = (cfg_dual && (hptr != PTR_LAST)) ? hptr + 1'b1 : '0;
    end

    assign wr_bank  = hptr;
    assign wr_addr  = wr_cnt[ADDR_W-1:0];
    assign full_vec = full_q;

    // Track the packet in flight: started, taken, bytes stored.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            rcv_act <= 1'b0;
            rcv_ok  <= 1'b0;
            wr_cnt  <= '0;
        end else if (pkt_end) begin
            rcv_act <= 1'b0;
            rcv_ok  <= 1'b0;
            wr_cnt  <= '0;
        end else if (pkt_wr) begin
            rcv_act <= 1'b1;
            if (rcv_start) begin
                rcv_ok <= accept_now;
            end
            if (wr_en) begin
                wr_cnt <= wr_cnt + 1'b1;
            end
        end
    end

    // Maintain bank occupancy, stored lengths and the fill pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            full_q   <= '0;
            bank_len <= '0;
            hptr     <= '0;
        end else begin
            if (rel_pulse) begin
                full_q[rel_bank] <= 1'b0;
            end
            if (commit) begin
                full_q[hptr]   <= 1'b1;
                bank_len[hptr] <= wr_cnt;
                hptr           <= hptr_next;
            end
        end
    end

    // Report the handshake one cycle after each end strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_ack   <= 1'b0;
        end else begin
            hs_valid <= pkt_end;
            hs_ack   <= commit;
        end
    end

    AST_NAK_NO_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && pkt_end && !rcv_act && full_q[hptr]) |=> (hs_valid && !hs_ack)); // R8
    AST_ACK_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> full_q[$past(hptr)]); // R2
    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= CNT_FULL); // R11
    AST_DISABLED_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && pkt_end) |=> (hs_valid && !hs_ack)); // R1

endmodule

// File: rtl/outep_cpu_side.sv
// Module: outep_cpu_side
// Firmware-facing half. It presents the next full bank by raising the
// received and bank-busy flags, loads the byte counter, steps the read
// position on each read, and releases the bank on a busy-clear strobe.
// Assumes the occupancy bits come from outep_host_side and react to the
// release pulse in the same cycle.
module outep_cpu_side #(
    parameter int unsigned BANK_BYTES = 64,
    parameter int unsigned NBANKS     = 2,
    localparam int unsigned ADDR_W    = $clog2(BANK_BYTES),
    localparam int unsigned CNT_W     = $clog2(BANK_BYTES + 1),
    localparam int unsigned PTR_W     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_enable,
    input  logic                         cfg_dual,
    input  logic                         irq_en,
    input  logic [NBANKS-1:0]            full_vec,
    input  logic [NBANKS-1:0][CNT_W-1:0] bank_len,
    input  logic                         cpu_rd,
    input  logic                         cpu_clr_rx,
    input  logic                         cpu_clr_busy,
    output logic                         rx_flag,
    output logic                         bank_busy,
    output logic                         irq,
    output logic [CNT_W-1:0]             byte_cnt,
    output logic [PTR_W-1:0]             rd_bank,
    output logic [ADDR_W-1:0]            rd_addr,
    output logic                         rel_pulse
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NBANKS - 1);

    logic              busy_q;
    logic              rx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] rd_idx;
    logic [PTR_W-1:0]  cptr;
    logic [PTR_W-1:0]  cptr_next;
    logic              present;
    logic              release_now;
    logic              rd_step;

    // Work out this cycle's presentation, release and read step.
    always_comb begin
        present     = cfg_enable && !busy_q && full_vec[cptr];
        release_now = cfg_enable && busy_q && cpu_clr_busy;
        rd_step     = cfg_enable && busy_q && cpu_rd && (cnt_q != '0);
        cptr_next   = (cfg_dual && (cptr != PTR_LAST)) ? cptr + 1'b1 : '0;
    end

    // Hold the current bank, its busy state and the read position.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rd_idx <= '0;
            cptr   <= '0;
        end else if (present) begin
            busy_q <= 1'b1;
            cnt_q  <= bank_len[cptr];
            rd_idx <= '0;
        end else if (release_now) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            rd_idx <= '0;
            cptr   <= cptr_next;
        end else if (rd_step) begin
            cnt_q  <= cnt_q - 1'b1;
            rd_idx <= rd_idx + 1'b1;
        end
    end

    // Keep the received flag: set on presentation, cleared by firmware.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_enable) begin
            rx_q <= 1'b0;
        end else if (present) begin
            rx_q <= 1'b1;
        end else if (cpu_clr_rx) begin
            rx_q <= 1'b0;
        end
    end

    assign rx_flag   = rx_q;
    assign bank_busy = busy_q;
    assign irq       = rx_q && irq_en;
    assign byte_cnt  = cnt_q;
    assign rd_bank   = cptr;
    assign rd_addr   = rd_idx;
    assign rel_pulse = release_now;

    AST_RX_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && busy_q && cpu_clr_rx && !cpu_clr_busy) |=> (busy_q && !rx_q)); // R4
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && busy_q && cpu_rd && !cpu_clr_busy && (cnt_q != '0))
        |=> (cnt_q == $past(cnt_q) - 1'b1)); // R5
    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && busy_q && cpu_rd && !cpu_clr_busy && (cnt_q == '0))
        |=> (cnt_q == '0) && busy_q); // R5
    AST_RELEASE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && busy_q && cpu_clr_busy && cfg_dual) |=> (cptr != $past(cptr))); // R6
    AST_IDLE_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !busy_q && cpu_clr_busy) |=> (cptr == $past(cptr))); // R13
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!busy_q && !rx_q && (cnt_q == '0))); // R1

endmodule

// File: rtl/outep_bank_mgr.sv
// Module: outep_bank_mgr (top)
// Receive-side buffer manager for one OUT endpoint with one or two banks.
// It ties together the packet side, the firmware side and the byte store.
// Assumes cfg_enable and cfg_dual are static while the endpoint is
// enabled, and that pkt_end is never raised together with pkt_wr.
module outep_bank_mgr
    import outep_pkg::*;
#(
    parameter int unsigned DATA_W     = EP_DATA_W,
    parameter int unsigned BANK_BYTES = EP_BANK_BYTES,
    localparam int unsigned NBANKS    = EP_NBANKS,
    localparam int unsigned ADDR_W    = $clog2(BANK_BYTES),
    localparam int unsigned CNT_W     = $clog2(BANK_BYTES + 1),
    localparam int unsigned PTR_W     = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_dual,
    input  logic              irq_en,
    input  logic              pkt_wr,
    input  logic [DATA_W-1:0] pkt_data,
    input  logic              pkt_end,
    output logic              hs_valid,
    output logic              hs_ack,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rd_data,
    output logic [CNT_W-1:0]  cpu_byte_cnt,
    input  logic              cpu_clr_rx,
    input  logic              cpu_clr_busy,
    output logic              rx_flag,
    output logic              bank_busy,
    output logic              irq
);

    logic                         wr_en;
    logic [PTR_W-1:0]             wr_bank;
    logic [ADDR_W-1:0]            wr_addr;
    logic [NBANKS-1:0]            full_vec;
    logic [NBANKS-1:0][CNT_W-1:0] bank_len;
    logic [PTR_W-1:0]             rd_bank;
    logic [ADDR_W-1:0]            rd_addr;
    logic                         rel_pulse;

    outep_host_side #(
        .BANK_BYTES (BANK_BYTES),
        .NBANKS     (NBANKS)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_enable (cfg_enable),
        .cfg_dual   (cfg_dual),
        .pkt_wr     (pkt_wr),
        .pkt_end    (pkt_end),
        .rel_pulse  (rel_pulse),
        .rel_bank   (rd_bank),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .full_vec   (full_vec),
        .bank_len   (bank_len),
        .hs_valid   (hs_valid),
        .hs_ack     (hs_ack)
    );

    outep_cpu_side #(
        .BANK_BYTES (BANK_BYTES),
        .NBANKS     (NBANKS)
    ) u_cpu (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_enable   (cfg_enable),
        .cfg_dual     (cfg_dual),
        .irq_en       (irq_en),
        .full_vec     (full_vec),
        .bank_len     (bank_len),
        .cpu_rd       (cpu_rd),
        .cpu_clr_rx   (cpu_clr_rx),
        .cpu_clr_busy (cpu_clr_busy),
        .rx_flag      (rx_flag),
        .bank_busy    (bank_busy),
        .irq          (irq),
        .byte_cnt     (cpu_byte_cnt),
        .rd_bank      (rd_bank),
        .rd_addr      (rd_addr),
        .rel_pulse    (rel_pulse)
    );

    outep_bank_store #(
        .DATA_W     (DATA_W),
        .BANK_BYTES (BANK_BYTES),
        .NBANKS     (NBANKS)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (pkt_data),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rd_data (cpu_rd_data)
    );

    AST_BUSY_OWNS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        bank_busy |-> full_vec[rd_bank]); // R6
    AST_FILL_SKIPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bank_busy) |-> (wr_bank != rd_bank)); // R8

endmodule

// File: tb/outep_bank_mgr_test.sv
module outep_bank_mgr_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_dual = 1'b0;
    logic       irq_en = 1'b0;
    logic       pkt_wr = 1'b0;
    logic [7:0] pkt_data = 8'h00;
    logic       pkt_end = 1'b0;
    logic       hs_valid;
    logic       hs_ack;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_rd_data;
    logic [6:0] cpu_byte_cnt;
    logic       cpu_clr_rx = 1'b0;
    logic       cpu_clr_busy = 1'b0;
    logic       rx_flag;
    logic       bank_busy;
    logic       irq;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    outep_bank_mgr uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_enable   (cfg_enable),
        .cfg_dual     (cfg_dual),
        .irq_en       (irq_en),
        .pkt_wr       (pkt_wr),
        .pkt_data     (pkt_data),
        .pkt_end      (pkt_end),
        .hs_valid     (hs_valid),
        .hs_ack       (hs_ack),
        .cpu_rd       (cpu_rd),
        .cpu_rd_data  (cpu_rd_data),
        .cpu_byte_cnt (cpu_byte_cnt),
        .cpu_clr_rx   (cpu_clr_rx),
        .cpu_clr_busy (cpu_clr_busy),
        .rx_flag      (rx_flag),
        .bank_busy    (bank_busy),
        .irq          (irq)
    );

    // Each entry: {length[15:8], seed[7:0]}; byte i carries seed + i.
    localparam logic [15:0] VECS [6] = '{16'h0110, 16'h05A0, 16'h4000,
                                         16'h0033, 16'h46F0, 16'h117F};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Send a packet; returns the handshake seen one cycle after the end strobe.
    task automatic send_pkt(input int len, input logic [7:0] seed,
                            output logic got_v, output logic got_a);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            pkt_wr   = 1'b1;
            pkt_data = 8'(seed + i);
        end
        @(negedge clk);
        pkt_wr  = 1'b0;
        pkt_end = 1'b1;
        @(negedge clk);
        pkt_end = 1'b0;
        got_v = hs_valid;
        got_a = hs_ack;
        @(negedge clk);
    endtask

    // Read n bytes, counting mismatches against seed + i.
    task automatic read_pkt(input int n, input logic [7:0] seed, output int bad);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            if (cpu_rd_data !== 8'(seed + i)) bad++;
            cpu_rd = 1'b1;
            @(negedge clk);
            cpu_rd = 1'b0;
        end
    endtask

    task automatic pulse_busy_clr();
        cpu_clr_busy = 1'b1;
        @(negedge clk);
        cpu_clr_busy = 1'b0;
    endtask

    task automatic pulse_rx_clr();
        cpu_clr_rx = 1'b1;
        @(negedge clk);
        cpu_clr_rx = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic v;
        logic a;
        int   bad;
        int   exp_n;

        repeat (3) @(negedge clk);
        chk(!rx_flag && !bank_busy && !irq && cpu_byte_cnt == 0 && !hs_valid,
            "R1 reset state", {rx_flag, bank_busy, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: disabled endpoint NAKs and stores nothing.
        send_pkt(4, 8'h22, v, a);
        chk(v && !a, "R1 disabled NAK", {v, a}, 2);
        chk(!bank_busy && !rx_flag, "R1 disabled nothing stored", bank_busy, 0);

        cfg_enable = 1'b1;
        irq_en     = 1'b1;
        @(negedge clk);

        // Table walk in single-bank mode (R2, R3, R4, R5, R6, R10, R11).
        foreach (VECS[k]) begin
            int         len;
            logic [7:0] seed;
            len   = int'(VECS[k][15:8]);
            seed  = VECS[k][7:0];
            exp_n = (len > 64) ? 64 : len;
            send_pkt(len, seed, v, a);
            chk(v && a, "R2 ACK on free bank", {v, a}, 3);
            chk(rx_flag && bank_busy, "R2 flags set", {rx_flag, bank_busy}, 3);
            chk(cpu_byte_cnt == 7'(exp_n), "R2 R10 R11 byte count", cpu_byte_cnt, exp_n);
            chk(irq, "R3 irq with enable", irq, 1);
            pulse_rx_clr();
            chk(!rx_flag && !irq && bank_busy && cpu_byte_cnt == 7'(exp_n),
                "R4 rx clear keeps bank", {rx_flag, irq, bank_busy}, 1);
            read_pkt(exp_n, seed, bad);
            chk(bad == 0, "R5 R11 data order", bad, 0);
            cpu_rd = 1'b1;
            @(negedge clk);
            cpu_rd = 1'b0;
            chk(cpu_byte_cnt == 0 && bank_busy, "R5 read at zero ignored", cpu_byte_cnt, 0);
            pulse_busy_clr();
            chk(!bank_busy && cpu_byte_cnt == 0, "R6 release frees", bank_busy, 0);
            @(negedge clk);
        end

        // R12 / R8: single bank held, second packet is NAKed.
        send_pkt(3, 8'h90, v, a);
        chk(v && a, "R12 first packet ACK", a, 1);
        send_pkt(5, 8'hC0, v, a);
        chk(v && !a, "R12 R8 held bank NAK", a, 0);
        chk(cpu_byte_cnt == 3, "R8 count unchanged", cpu_byte_cnt, 3);
        read_pkt(3, 8'h90, bad);
        chk(bad == 0, "R8 held data unchanged", bad, 0);
        pulse_busy_clr();
        @(negedge clk);
        chk(!bank_busy, "R12 no phantom packet", bank_busy, 0);
        send_pkt(2, 8'h05, v, a);
        chk(v && a, "R12 ACK after release", a, 1);
        read_pkt(2, 8'h05, bad);
        chk(bad == 0, "R12 data after release", bad, 0);
        pulse_busy_clr();
        @(negedge clk);

        // Dual-bank mode (R6, R7, R8, R9).
        cfg_dual = 1'b1;
        @(negedge clk);
        send_pkt(3, 8'h40, v, a);
        chk(a, "R7 packet A to bank 0", a, 1);
        send_pkt(4, 8'h50, v, a);
        chk(a, "R7 packet B accepted while A held", a, 1);
        send_pkt(2, 8'hE0, v, a);
        chk(v && !a, "R8 both banks full NAK", a, 0);
        chk(cpu_byte_cnt == 3 && bank_busy, "R8 current bank unchanged", cpu_byte_cnt, 3);
        read_pkt(3, 8'h40, bad);
        chk(bad == 0, "R7 data of A", bad, 0);
        pulse_busy_clr();
        chk(!bank_busy, "R9 one idle cycle after release", bank_busy, 1'b0);
        @(negedge clk);
        chk(bank_busy && rx_flag && cpu_byte_cnt == 4, "R9 next bank presented",
            cpu_byte_cnt, 4);
        read_pkt(4, 8'h50, bad);
        chk(bad == 0, "R6 R7 data of B from other bank", bad, 0);
        pulse_busy_clr();
        @(negedge clk);
        chk(!bank_busy, "R6 nothing left", bank_busy, 0);
        send_pkt(2, 8'h60, v, a);
        chk(a && bank_busy, "R7 round robin back to bank 0", a, 1);
        read_pkt(2, 8'h60, bad);
        chk(bad == 0, "R7 data of D", bad, 0);
        pulse_busy_clr();
        @(negedge clk);

        // R13: idle release strobe must not move the firmware side.
        pulse_busy_clr();
        pulse_rx_clr();
        chk(!bank_busy, "R13 idle strobe no effect", bank_busy, 0);
        send_pkt(1, 8'h70, v, a);
        chk(a && bank_busy && cpu_byte_cnt == 1, "R13 next packet still presented",
            {a, bank_busy}, 3);
        read_pkt(1, 8'h70, bad);
        chk(bad == 0, "R13 data of E", bad, 0);

        // R3: interrupt masked by enable.
        irq_en = 1'b0;
        @(negedge clk);
        chk(rx_flag && !irq, "R3 irq masked", irq, 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq, "R3 irq unmasked", irq, 1);

        // R1: reset while a bank is held.
        rst_n = 1'b0;
        @(negedge clk);
        chk(!bank_busy && !rx_flag && !irq && cpu_byte_cnt == 0, "R1 reset clears",
            {bank_busy, rx_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule